// File: doc/BRIEF.md
# Header-Routed Two-Way Packet Fork

The block receives packets one byte per clock on a single input with a valid strobe. Each packet opens with a one-byte destination tag and a one-byte length (3 to 32), followed by payload. The valid strobe is high for every byte of a packet with no gaps, and the packet ends when valid drops. Every packet leaves on output 0, on output 1, or on both, byte for byte and with a contiguous valid strobe.

Software sets the routing through a small write-only register bank. Two filters can be turned on. The first compares the tag with a reference under a bit mask. The second checks whether the length falls inside an inclusive window. A packet that matches any enabled filter is sent to output 1, and every other packet is sent to output 0. A broadcast mode copies every packet to both outputs.

The input is held back two byte times, so the tag and the length are both known before the first byte goes out. No other buffering is kept. The register settings are sampled when a packet starts and stay fixed for the whole of that packet.

Top module: `pkt_fork_switch`

## Requirements
- R1: A write (`cfg_wr` high at a clock edge) stores `cfg_val` in the register chosen by `cfg_sel`: 3'b000 mode, 3'b010 tag reference, 3'b011 tag mask, 3'b100 lower length limit, 3'b101 upper length limit. Writes to 3'b001, 3'b110 and 3'b111 change nothing.
- R2: Mode bits: bit 0 enables the tag filter, bit 1 enables the length filter, bit 2 selects broadcast. Mode bits 7:3 are ignored.
- R3: The tag filter matches when `(tag & mask) == (reference & mask)`. The tag is the first byte of the packet.
- R4: The length filter matches when `lower <= len` and `len <= upper`, with both limits included. The length is the second byte of the packet.
- R5: A packet is filtered when any enabled filter matches it. A filtered packet goes only to output 1 and an unfiltered packet goes only to output 0. With both filters off, every packet goes to output 0. In broadcast mode the packet goes to both outputs.
- R6: A byte sampled at clock edge t appears on a chosen output right after edge t+2. Output valid is low whenever no packet byte is being sent, and the output byte is 0 while valid is low.
- R7: The settings are captured at the edge that samples a packet's first byte. A write at that same edge, or at any later edge of the packet, takes effect from the next packet onward.
- R8: Asynchronous active-low reset clears all registers to 0 and drives both output valids low.
- R9: Packets separated by a single idle cycle are each routed by their own header and settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_byte | input | DATA_W | Incoming packet byte |
| in_vld | input | 1 | Incoming byte valid; its falling edge ends the packet |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_val | input | DATA_W | Register write value |
| out0_byte | output | DATA_W | Output 0 byte |
| out0_vld | output | 1 | Output 0 valid |
| out1_byte | output | DATA_W | Output 1 byte |
| out1_vld | output | 1 | Output 1 valid |

## Verification
Directed packets place the length exactly on each window limit and one step outside it. They also use a window of a single value, an all-zero mask that makes every tag match, and both filters enabled with only one of them matching. Together these separate an inclusive comparison from an exclusive one and an OR of the filters from an AND. Further directed cases write the unused selects, and write the registers on the first byte or in the middle of a packet. These show whether address decoding aliases and whether the settings are sampled at the right edge. Random packets with gaps of one to three cycles mix all four modes, and every output byte is compared against a per-port expected stream and the delayed input.

// File: rtl/pktsw_pkg.sv
package pktsw_pkg;
    localparam int unsigned SEL_W     = 3;
    localparam int unsigned MODE_W    = 3;
    localparam int unsigned MODE_TAG  = 0;
    localparam int unsigned MODE_LEN  = 1;
    localparam int unsigned MODE_BC   = 2;
    localparam int unsigned NPORT     = 2;

    localparam logic [SEL_W-1:0] SEL_MODE = 3'b000;
    localparam logic [SEL_W-1:0] SEL_REF  = 3'b010;
    localparam logic [SEL_W-1:0] SEL_MASK = 3'b011;
    localparam logic [SEL_W-1:0] SEL_LO   = 3'b100;
    localparam logic [SEL_W-1:0] SEL_HI   = 3'b101;
endpackage

// File: rtl/pktsw_cfg_regs.sv
module pktsw_cfg_regs import pktsw_pkg::*; #(
    parameter int unsigned DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [SEL_W-1:0]  sel,
    input  logic [DW-1:0]     val,
    input  logic              take,
    output logic [MODE_W-1:0] mode,
    output logic [DW-1:0]     tag_ref,
    output logic [DW-1:0]     tag_mask,
    output logic [DW-1:0]     len_lo,
    output logic [DW-1:0]     len_hi
);
    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [DW-1:0]     tref;
        logic [DW-1:0]     tmask;
        logic [DW-1:0]     lo;
        logic [DW-1:0]     hi;
    } cfg_t;

    typedef struct packed {
        cfg_t live;
        cfg_t snap;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // snapshot uses the value held before this edge's write
        if (take) st_d.snap = st_q.live;
        if (wr) begin
            case (sel)
                SEL_MODE: st_d.live.mode  = val[MODE_W-1:0];
                SEL_REF:  st_d.live.tref  = val;
                SEL_MASK: st_d.live.tmask = val;
                SEL_LO:   st_d.live.lo    = val;
                SEL_HI:   st_d.live.hi    = val;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode     = st_q.snap.mode;
    assign tag_ref  = st_q.snap.tref;
    assign tag_mask = st_q.snap.tmask;
    assign len_lo   = st_q.snap.lo;
    assign len_hi   = st_q.snap.hi;
endmodule

// File: rtl/pktsw_hdr_pipe.sv
module pktsw_hdr_pipe #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [DW-1:0] in_byte,
    output logic          sop_in,
    output logic          head_vld,
    output logic          head_sop,
    output logic [DW-1:0] head_byte,
    output logic [DW-1:0] next_byte
);
    localparam int unsigned DEPTH = 2;

    typedef struct packed {
        logic          vld;
        logic          sop;
        logic [DW-1:0] data;
    } slot_t;

    slot_t [DEPTH-1:0] pipe_d, pipe_q;

    assign sop_in = in_vld & ~pipe_q[0].vld;

    always_comb begin
        pipe_d[0].vld  = in_vld;
        pipe_d[0].sop  = sop_in;
        pipe_d[0].data = in_vld ? in_byte : '0;
        for (int i = 1; i < DEPTH; i++) pipe_d[i] = pipe_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign head_vld  = pipe_q[DEPTH-1].vld;
    assign head_sop  = pipe_q[DEPTH-1].sop;
    assign head_byte = pipe_q[DEPTH-1].data;
    assign next_byte = pipe_q[DEPTH-2].data;
endmodule

// File: rtl/pktsw_classify.sv
module pktsw_classify import pktsw_pkg::*; #(
    parameter int unsigned DW = 8
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [DW-1:0]     tag_ref,
    input  logic [DW-1:0]     tag_mask,
    input  logic [DW-1:0]     len_lo,
    input  logic [DW-1:0]     len_hi,
    input  logic [DW-1:0]     tag,
    input  logic [DW-1:0]     len,
    output logic [NPORT-1:0]  fwd
);
    logic tag_hit, len_hit, filtered;

    always_comb begin
        tag_hit  = ((tag ^ tag_ref) & tag_mask) == '0;
        len_hit  = (len >= len_lo) && (len <= len_hi);
        filtered = (mode[MODE_TAG] & tag_hit) | (mode[MODE_LEN] & len_hit);
        fwd[0]   = ~filtered | mode[MODE_BC];
        fwd[1]   =  filtered | mode[MODE_BC];
    end
endmodule

// File: rtl/pkt_fork_switch.sv
module pkt_fork_switch import pktsw_pkg::*; #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_byte,
    input  logic              in_vld,
    input  logic              cfg_wr,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [DATA_W-1:0] cfg_val,
    output logic [DATA_W-1:0] out0_byte,
    output logic              out0_vld,
    output logic [DATA_W-1:0] out1_byte,
    output logic              out1_vld
);
    logic              sop_in, head_vld, head_sop;
    logic [DATA_W-1:0] head_byte, next_byte;
    logic [MODE_W-1:0] mode;
    logic [DATA_W-1:0] tag_ref, tag_mask, len_lo, len_hi;
    logic [NPORT-1:0]  fwd;

    pktsw_cfg_regs #(.DW(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .sel(cfg_sel), .val(cfg_val),
        .take(sop_in), .mode(mode), .tag_ref(tag_ref), .tag_mask(tag_mask),
        .len_lo(len_lo), .len_hi(len_hi)
    );

    pktsw_hdr_pipe #(.DW(DATA_W)) u_pipe (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_byte(in_byte),
        .sop_in(sop_in), .head_vld(head_vld), .head_sop(head_sop),
        .head_byte(head_byte), .next_byte(next_byte)
    );

    pktsw_classify #(.DW(DATA_W)) u_cls (
        .mode(mode), .tag_ref(tag_ref), .tag_mask(tag_mask),
        .len_lo(len_lo), .len_hi(len_hi),
        .tag(head_byte), .len(next_byte), .fwd(fwd)
    );

    typedef struct packed {
        logic [NPORT-1:0]             route;
        logic [NPORT-1:0]             vld;
        logic [NPORT-1:0][DATA_W-1:0] data;
    } out_t;

    out_t             o_d, o_q;
    logic [NPORT-1:0] route_now;

    always_comb begin
        o_d       = o_q;
        route_now = head_sop ? fwd : o_q.route;
        if (head_vld && head_sop) o_d.route = fwd;
        for (int p = 0; p < NPORT; p++) begin
            o_d.vld[p]  = head_vld & route_now[p];
            o_d.data[p] = o_d.vld[p] ? head_byte : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign out0_vld  = o_q.vld[0];
    assign out1_vld  = o_q.vld[1];
    assign out0_byte = o_q.data[0];
    assign out1_byte = o_q.data[1];
endmodule

// File: rtl/pktsw_chk.sv
module pktsw_chk #(
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] in_byte,
    input logic          in_vld,
    input logic [DW-1:0] out0_byte,
    input logic          out0_vld,
    input logic [DW-1:0] out1_byte,
    input logic          out1_vld
);
    // R6
    out0_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out0_vld |-> (out0_byte == $past(in_byte, 3)) && $past(in_vld, 3));
    // R6
    out1_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out1_vld |-> (out1_byte == $past(in_byte, 3)) && $past(in_vld, 3));
    // R5
    some_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_vld, 3) |-> (out0_vld || out1_vld));
    // R5
    bc_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out0_vld && out1_vld) |-> (out0_byte == out1_byte));
    // R6
    out0_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out0_vld) |-> !$past(in_vld, 3));
    // R6
    out1_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out1_vld) |-> !$past(in_vld, 3));
    // R7
    out0_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out0_vld) |-> !$past(in_vld, 4));
    // R6
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!out0_vld |-> out0_byte == '0) and (!out1_vld |-> out1_byte == '0));
endmodule

bind pkt_fork_switch pktsw_chk #(.DW(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_vld(in_vld),
    .out0_byte(out0_byte), .out0_vld(out0_vld),
    .out1_byte(out1_byte), .out1_vld(out1_vld)
);

// File: tb/pkt_fork_switch_tb.sv
module pkt_fork_switch_tb;
    localparam int QD = 4096;

    logic       clk = 0;
    logic       rst_n = 0;
    logic [7:0] in_byte = 0;
    logic       in_vld = 0;
    logic       cfg_wr = 0;
    logic [2:0] cfg_sel = 0;
    logic [7:0] cfg_val = 0;
    logic [7:0] out0_byte, out1_byte;
    logic       out0_vld, out1_vld;

    always #4 clk = ~clk;

    pkt_fork_switch u_dut (
        .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_vld(in_vld),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_val(cfg_val),
        .out0_byte(out0_byte), .out0_vld(out0_vld),
        .out1_byte(out1_byte), .out1_vld(out1_vld)
    );

    int checks = 0, errors = 0;
    bit finished = 0;

    // bench model of the register bank
    logic [7:0] m_mode = 0, m_ref = 0, m_mask = 0, m_lo = 0, m_hi = 0;
    logic [7:0] exp0 [QD], exp1 [QD];
    int wp0 = 0, rp0 = 0, wp1 = 0, rp1 = 0;
    int ep0 = 0, ep1 = 0, cnt0 = 0, cnt1 = 0;
    logic [2:0] hv;
    logic [7:0] hb [3];
    logic prev0 = 0, prev1 = 0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic void model_wr(input logic [2:0] s, input logic [7:0] v);
        case (s)
            3'b000: m_mode = v;
            3'b010: m_ref  = v;
            3'b011: m_mask = v;
            3'b100: m_lo   = v;
            3'b101: m_hi   = v;
            default: ;
        endcase
    endfunction

    function automatic logic [1:0] route(input logic [7:0] a, input logic [7:0] l);
        bit th, lh, f;
        th = ((a & m_mask) == (m_ref & m_mask));
        lh = (m_lo <= l) && (l <= m_hi);
        f  = (m_mode[0] && th) || (m_mode[1] && lh);
        return {f || m_mode[2], !f || m_mode[2]};
    endfunction

    task automatic wr(input logic [2:0] s, input logic [7:0] v);
        @(negedge clk);
        cfg_wr = 1; cfg_sel = s; cfg_val = v;
        @(negedge clk);
        cfg_wr = 0;
        model_wr(s, v);
    endtask

    // send one packet; optional write at byte index midx (R7)
    task automatic send(input logic [7:0] a, input logic [7:0] l,
                        input int midx, input logic [2:0] ms, input logic [7:0] mv,
                        input int gap);
        logic [1:0] r;
        logic [7:0] b;
        r = route(a, l);
        if (r[0]) ep0++;
        if (r[1]) ep1++;
        for (int i = 0; i < l; i++) begin
            b = (i == 0) ? a : (i == 1) ? l : 8'($urandom);
            @(negedge clk);
            in_vld = 1; in_byte = b;
            cfg_wr = (i == midx); cfg_sel = ms; cfg_val = mv;
            if (i == midx) model_wr(ms, mv);
            if (r[0]) begin exp0[wp0 % QD] = b; wp0++; end
            if (r[1]) begin exp1[wp1 % QD] = b; wp1++; end
        end
        @(negedge clk);
        in_vld = 0; in_byte = 0; cfg_wr = 0;
        for (int g = 1; g < gap; g++) @(negedge clk);
    endtask

    task automatic drain();
        repeat (6) @(negedge clk);
        chk(wp0 == rp0, "R5 port0 bytes", rp0, wp0);
        chk(wp1 == rp1, "R5 port1 bytes", rp1, wp1);
        chk(cnt0 == ep0, "R6 port0 packets", cnt0, ep0);
        chk(cnt1 == ep1, "R6 port1 packets", cnt1, ep1);
    endtask

    // monitor: sampled 1 ns after each rising edge
    always @(posedge clk) begin
        #1;
        if (!rst_n) begin
            hv = 0; hb[0] = 0; hb[1] = 0; hb[2] = 0; prev0 = 0; prev1 = 0;
        end else begin
            hv = {hv[1:0], in_vld};
            hb[2] = hb[1]; hb[1] = hb[0]; hb[0] = in_byte;
            chk((out0_vld | out1_vld) == hv[2], "R6 valid timing", out0_vld | out1_vld, hv[2]);
            if (out0_vld) begin
                chk(out0_byte == hb[2], "R6 port0 delay", out0_byte, hb[2]);
                if (rp0 < wp0) begin
                    chk(out0_byte == exp0[rp0 % QD], "R5 port0 stream", out0_byte, exp0[rp0 % QD]);
                    rp0++;
                end else chk(0, "R5 port0 unexpected byte", out0_byte, -1);
            end else chk(out0_byte == 0, "R6 port0 idle byte", out0_byte, 0);
            if (out1_vld) begin
                chk(out1_byte == hb[2], "R6 port1 delay", out1_byte, hb[2]);
                if (rp1 < wp1) begin
                    chk(out1_byte == exp1[rp1 % QD], "R5 port1 stream", out1_byte, exp1[rp1 % QD]);
                    rp1++;
                end else chk(0, "R5 port1 unexpected byte", out1_byte, -1);
            end
            if (prev0 && !out0_vld) cnt0++;
            if (prev1 && !out1_vld) cnt1++;
            prev0 = out0_vld; prev1 = out1_vld;
        end
    end

    initial begin
        #(200000 * 8);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(!out0_vld && !out1_vld, "R8 reset valid", {out0_vld, out1_vld}, 0);
        rst_n = 1;
        // R8/R5: cleared registers route to port 0
        send(8'h5A, 8'd5, -1, 0, 0, 1);
        drain();
        chk(ep1 == 0, "R5 default no port1", ep1, 0);

        // R3: masked tag compare, R2 bit 0
        wr(3'b010, 8'hA5); wr(3'b011, 8'hF0); wr(3'b000, 8'h01);
        send(8'hA0, 8'd4, -1, 0, 0, 1);   // match upper nibble -> port1
        send(8'h50, 8'd4, -1, 0, 0, 1);   // mismatch -> port0
        wr(3'b011, 8'h00);
        send(8'h13, 8'd3, -1, 0, 0, 2);   // mask 0 matches all (R3)
        // R4: inclusive window, R2 bit 1
        wr(3'b000, 8'h02); wr(3'b100, 8'd8); wr(3'b101, 8'd12);
        send(8'h00, 8'd7,  -1, 0, 0, 1);
        send(8'h00, 8'd8,  -1, 0, 0, 1);
        send(8'h00, 8'd12, -1, 0, 0, 1);
        send(8'h00, 8'd13, -1, 0, 0, 1);
        wr(3'b100, 8'd20); wr(3'b101, 8'd20);
        send(8'h00, 8'd20, -1, 0, 0, 1);
        send(8'h00, 8'd21, -1, 0, 0, 1);
        // R5: both filters, only one matching (OR)
        wr(3'b000, 8'h03); wr(3'b011, 8'hFF); wr(3'b010, 8'h77);
        send(8'h77, 8'd3,  -1, 0, 0, 1);
        send(8'h76, 8'd20, -1, 0, 0, 1);
        send(8'h76, 8'd9,  -1, 0, 0, 1);
        // R2: broadcast, upper mode bits ignored
        wr(3'b000, 8'hFC);
        send(8'h11, 8'd6, -1, 0, 0, 1);
        // R1: unused selects ignored
        wr(3'b000, 8'h01);
        wr(3'b001, 8'h04); wr(3'b110, 8'h00); wr(3'b111, 8'h00);
        send(8'h77, 8'd5, -1, 0, 0, 1);
        send(8'h10, 8'd5, -1, 0, 0, 1);
        drain();
        // R7: writes at first byte and mid-packet apply to the next packet
        send(8'h10, 8'd6, 0, 3'b000, 8'h04, 1);
        send(8'h10, 8'd6, 3, 3'b000, 8'h00, 1);
        send(8'h10, 8'd6, -1, 0, 0, 1);
        drain();
        // R8: reset clears configuration
        wr(3'b000, 8'h04);
        @(negedge clk); rst_n = 0; model_wr(0, 0); model_wr(2, 0); model_wr(3, 0);
        model_wr(4, 0); model_wr(5, 0);
        @(negedge clk);
        chk(!out0_vld && !out1_vld, "R8 reset valid again", {out0_vld, out1_vld}, 0);
        rst_n = 1;
        send(8'h22, 8'd4, -1, 0, 0, 1);
        drain();
        chk(ep1 == cnt1, "R8 config cleared", cnt1, ep1);

        // R9 and random mix with 1..3 idle cycles between packets
        for (int n = 0; n < 300; n++) begin
            logic [7:0] lo;
            int m;
            if (n % 10 == 0) begin
                m  = $urandom_range(0, 3);
                lo = 8'($urandom_range(3, 32));
                wr(3'b010, 8'($urandom)); wr(3'b011, 8'($urandom));
                wr(3'b100, lo); wr(3'b101, 8'($urandom_range(lo, 32)));
                wr(3'b000, (m == 0) ? 8'h00 : (m == 1) ? 8'h04 : (m == 2) ? 8'h01 : 8'h02);
            end
            send(8'($urandom), 8'($urandom_range(3, 32)), -1, 0, 0, $urandom_range(1, 3));
        end
        drain();

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule